// File: doc/BRIEF.md
# Indirect Extended-Register Window for a PHY Management Port

This block sits behind an MDIO frame decoder inside a PHY. It gives the management station a path into an extended register space that the 32 ordinary management registers cannot reach. The path is a pair of management registers. The control register (address 13) selects a target device and a function. The window register (address 14) carries either an address pointer or the data at that pointer.

Every 5-bit device address keeps its own 16-bit pointer. A pointer is loaded through the window while the function field is 00. Data accesses then go to the extended register that the selected device's pointer names. Depending on the function, the pointer stays where it is, moves on after every data access, or moves on after data writes only.

The block holds the extended registers of device 0x1F. Two of them are implemented:
- a clock-delay enable register, whose bits drive the transmit and receive delay-enable outputs;
- a delay-code register, whose fields drive the two 4-bit delay-code outputs.

To write an extended register, the station writes the control register with function 00, writes the target address to the window, rewrites the control register with a data function, and then writes the data to the window. A read uses the same first three steps and then reads the window.

Top module: `mmd_window_bridge`

## Requirements
- R1: Reset clears the control register, every device pointer, both delay-enable bits, both delay codes and the read-data output.
- R2: A write to management register 13 stores bits [4:0] as the selected device and bits [15:14] as the function. A read of register 13 returns those bits, with bits [13:5] read as zero. Read data for any read appears on `rd_data` in the cycle after the read strobe and holds until the next read.
- R3: With function 00, a write to register 14 loads the pointer of the selected device only, and a read of register 14 returns that pointer. The pointers of all other devices do not change.
- R4: With function 01, reads and writes of register 14 reach the extended register at the selected device's pointer, and the pointer does not change.
- R5: With function 10, the selected device's pointer increments by one after each read and each write of register 14, and it wraps from 0xFFFF to 0x0000.
- R6: With function 11, the selected device's pointer increments after each write of register 14 but not after a read.
- R7: In device 0x1F, extended address 0x0032 holds the delay enables: bit 1 drives `tx_dly_en` and bit 0 drives `rx_dly_en`. Its other bits read as zero.
- R8: In device 0x1F, extended address 0x0086 holds the delay codes: bits [3:0] drive `rx_dly_code` and bits [7:4] drive `tx_dly_code`. Bits [15:8] read as zero.
- R9: A data read at any other extended address, or at any address of any other device, returns 0x0000. A data write there changes no output and no implemented register.
- R10: A read of a management address other than 13 or 14 returns 0x0000. A write to such an address changes nothing. A read strobe that arrives together with a write strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | One-cycle write strobe from the frame decoder |
| rd_en | input | 1 | One-cycle read strobe from the frame decoder |
| reg_addr | input | 5 | Management register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid from the cycle after `rd_en` |
| tx_dly_en | output | 1 | Transmit clock delay enable |
| rx_dly_en | output | 1 | Receive clock delay enable |
| tx_dly_code | output | 4 | Transmit delay code |
| rx_dly_code | output | 4 | Receive delay code |

## Verification
Most state errors in this block are invisible until a later access uses the wrong state.

A wrong pointer, a wrong selected device or a wrong function shows up at the ports in one of three places:
- the next read of register 14 in function 00;
- a data read that lands on the wrong extended register;
- a delay output that changes after a write meant for another address.

Every read is therefore compared one cycle after its strobe. The delay outputs are compared after every write, so a stray write is caught at the write itself rather than at some later readback.

// File: rtl/mmd_window_bridge.sv
module mmd_window_bridge #(
  parameter int          DEV_BITS  = 5,
  parameter int          CODE_W    = 4,
  parameter logic [4:0]  CTL_REG   = 5'd13,
  parameter logic [4:0]  WIN_REG   = 5'd14,
  parameter logic [4:0]  PHY_DEV   = 5'h1F,
  parameter logic [15:0] EN_ADDR   = 16'h0032,
  parameter logic [15:0] CODE_ADDR = 16'h0086
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [4:0]        reg_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic              tx_dly_en,
  output logic              rx_dly_en,
  output logic [CODE_W-1:0] tx_dly_code,
  output logic [CODE_W-1:0] rx_dly_code
);
  localparam int NDEV = 1 << DEV_BITS;
  localparam int PADW = 16 - 2 * CODE_W;

  logic [DEV_BITS-1:0] sel_dev;
  logic [1:0]          func;
  logic [15:0]         ptr [NDEV];
  logic [1:0]          dly_en;
  logic [2*CODE_W-1:0] dly_code;
  logic [15:0]         ext_rd;

  wire        rd_ok     = rd_en & ~wr_en;
  wire        ctl_wr    = wr_en && reg_addr == CTL_REG;
  wire        win_wr    = wr_en && reg_addr == WIN_REG;
  wire        win_rd    = rd_ok && reg_addr == WIN_REG;
  wire        data_mode = func != 2'b00;
  wire        on_phy    = sel_dev == PHY_DEV[DEV_BITS-1:0];
  wire [15:0] cur_ptr   = ptr[sel_dev];
  wire        bump      = data_mode && ((win_wr && func[1]) || (win_rd && func == 2'b10));
  wire        ext_wr    = win_wr && data_mode && on_phy;

  always_comb begin
    ext_rd = 16'h0000;
    if (on_phy && cur_ptr == EN_ADDR)   ext_rd = {14'b0, dly_en};
    if (on_phy && cur_ptr == CODE_ADDR) ext_rd = {{PADW{1'b0}}, dly_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_dev <= '0;
      func    <= 2'b00;
    end else if (ctl_wr) begin
      sel_dev <= wr_data[DEV_BITS-1:0];
      func    <= wr_data[15:14];
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr[d] <= 16'h0000;
      else if (sel_dev == DEV_BITS'(d)) begin
        if (win_wr && !data_mode) ptr[d] <= wr_data;
        else if (bump)            ptr[d] <= ptr[d] + 16'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_en   <= 2'b00;
      dly_code <= '0;
    end else if (ext_wr) begin
      if (cur_ptr == EN_ADDR)   dly_en   <= wr_data[1:0];
      if (cur_ptr == CODE_ADDR) dly_code <= wr_data[2*CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_data <= 16'h0000;
    else if (rd_ok) begin
      case (reg_addr)
        CTL_REG: rd_data <= {func, {(14-DEV_BITS){1'b0}}, sel_dev};
        WIN_REG: rd_data <= data_mode ? ext_rd : cur_ptr;
        default: rd_data <= 16'h0000;
      endcase
    end
  end

  assign tx_dly_en   = dly_en[1];
  assign rx_dly_en   = dly_en[0];
  assign rx_dly_code = dly_code[CODE_W-1:0];
  assign tx_dly_code = dly_code[2*CODE_W-1:CODE_W];

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable({func, sel_dev}));

  // R5
  incr_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr || win_rd) && func == 2'b10 |=> cur_ptr == $past(cur_ptr) + 16'd1);

  // R6
  rd_noincr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_rd && func == 2'b11 |=> $stable(cur_ptr));

  // R4
  no_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr || win_rd) && func == 2'b01 |=> $stable(cur_ptr));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr |=> $stable({tx_dly_en, rx_dly_en, tx_dly_code, rx_dly_code}));

  // R10
  other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok && reg_addr != CTL_REG && reg_addr != WIN_REG |=> rd_data == 16'h0000);
endmodule

// File: tb/tb_mmd_window_bridge.sv
`timescale 1ns/1ps
module tb_mmd_window_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        tx_dly_en, rx_dly_en;
  logic [3:0]  tx_dly_code, rx_dly_code;

  int n_chk = 0, n_bad = 0;

  mmd_window_bridge dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .tx_dly_en(tx_dly_en), .rx_dly_en(rx_dly_en),
    .tx_dly_code(tx_dly_code), .rx_dly_code(rx_dly_code));

  always #2.5 clk = ~clk;

  logic [4:0]  m_dev = '0;
  logic [1:0]  m_fn  = '0;
  logic [15:0] m_ptr [32];
  logic [1:0]  m_en   = '0;
  logic [7:0]  m_code = '0;

  function automatic logic [15:0] m_ext();
    if (m_dev == 5'h1F && m_ptr[m_dev] == 16'h0032) return {14'b0, m_en};
    if (m_dev == 5'h1F && m_ptr[m_dev] == 16'h0086) return {8'b0, m_code};
    return 16'h0000;
  endfunction

  function automatic string fn_tag(logic [1:0] f);
    case (f)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    check(tag, {14'b0, tx_dly_en, rx_dly_en}, {14'b0, m_en});
    check(tag, {8'b0, tx_dly_code, rx_dly_code}, {8'b0, m_code});
  endtask

  task automatic do_wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 5'd13) begin
      m_dev = d[4:0];
      m_fn  = d[15:14];
    end else if (a == 5'd14) begin
      if (m_fn == 2'b00) m_ptr[m_dev] = d;
      else begin
        if (m_dev == 5'h1F && m_ptr[m_dev] == 16'h0032) m_en = d[1:0];
        if (m_dev == 5'h1F && m_ptr[m_dev] == 16'h0086) m_code = d[7:0];
        if (m_fn[1]) m_ptr[m_dev] = m_ptr[m_dev] + 16'd1;
      end
    end
    check_outs((a == 5'd14 && m_fn != 2'b00) ? "R7" : "R9");
  endtask

  task automatic do_rd(logic [4:0] a, string tag);
    logic [15:0] exp;
    if (a == 5'd13)      exp = {m_fn, 9'b0, m_dev};
    else if (a == 5'd14) exp = (m_fn == 2'b00) ? m_ptr[m_dev] : m_ext();
    else                 exp = 16'h0000;
    if (a == 5'd14 && m_fn == 2'b10) m_ptr[m_dev] = m_ptr[m_dev] + 16'd1;
    @(negedge clk);
    rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_ptr[i] = 16'h0000;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1", rd_data, 16'h0000);
    check_outs("R1");
    do_rd(5'd13, "R1");
    do_rd(5'd14, "R1");

    // R2: control register readback, middle bits dropped
    do_wr(5'd13, 16'hFFE3);
    do_rd(5'd13, "R2");

    // R7: four-step write to the enable register, then read it back
    do_wr(5'd13, 16'h001F);
    do_wr(5'd14, 16'h0032);
    do_wr(5'd13, 16'h401F);
    do_wr(5'd14, 16'hFFFE);
    check("R7", {15'b0, tx_dly_en}, 16'h0001);
    do_rd(5'd14, "R7");
    do_rd(5'd14, "R4");

    // R8: delay codes
    do_wr(5'd13, 16'h001F);
    do_wr(5'd14, 16'h0086);
    do_wr(5'd13, 16'h401F);
    do_wr(5'd14, 16'hABA8);
    check("R8", {12'b0, rx_dly_code}, 16'h0008);
    check("R8", {12'b0, tx_dly_code}, 16'h000A);
    do_rd(5'd14, "R8");

    // R3: pointer isolation between devices
    do_wr(5'd13, 16'h0003);
    do_wr(5'd14, 16'h1234);
    do_wr(5'd13, 16'h001F);
    do_rd(5'd14, "R3");
    do_wr(5'd13, 16'h0003);
    do_rd(5'd14, "R3");

    // R9: other device at an implemented address
    do_wr(5'd14, 16'h0032);
    do_wr(5'd13, 16'h4003);
    do_wr(5'd14, 16'h0000);
    do_rd(5'd14, "R9");

    // R5: wrap from 0xFFFF
    do_wr(5'd13, 16'h001F);
    do_wr(5'd14, 16'hFFFF);
    do_wr(5'd13, 16'h801F);
    do_rd(5'd14, "R5");
    do_wr(5'd13, 16'h001F);
    do_rd(5'd14, "R5");

    // R6: read leaves the pointer, write moves it
    do_wr(5'd14, 16'h0032);
    do_wr(5'd13, 16'hC01F);
    do_rd(5'd14, "R6");
    do_rd(5'd14, "R6");
    do_wr(5'd14, 16'h0001);
    do_wr(5'd13, 16'h001F);
    do_rd(5'd14, "R6");

    // R10: other addresses, and a read together with a write
    do_wr(5'd7, 16'hFFFF);
    do_rd(5'd7, "R10");
    do_rd(5'd13, "R10");
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; reg_addr = 5'd2; wr_data = 16'h0;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10", rd_data, {m_fn, 9'b0, m_dev});

    // random phase
    for (int k = 0; k < 600; k++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 2) begin
        logic [4:0] dv = ($urandom_range(0, 2) != 0) ? 5'h1F : 5'($urandom);
        do_wr(5'd13, {2'($urandom), 9'($urandom), dv});
      end else if (r < 5) begin
        logic [15:0] v;
        case ($urandom_range(0, 4))
          0: v = 16'h0032;
          1: v = 16'h0086;
          2: v = 16'h0031;
          3: v = 16'hFFFF;
          default: v = 16'($urandom);
        endcase
        do_wr(5'd14, (m_fn == 2'b00) ? v : 16'($urandom));
      end else if (r < 8) begin
        do_rd(5'd14, fn_tag(m_fn));
      end else if (r < 9) begin
        do_rd(5'd13, "R2");
      end else begin
        logic [4:0] oa = 5'($urandom_range(0, 12));
        do_rd(oa, "R10");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule